// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block is the per-pin interrupt and wake logic of a general-purpose I/O pad. It watches the already filtered input level of one pin and, according to a small control word, turns level conditions or edges on that pin into a sticky interrupt status bit and a sticky wake status bit. The interrupt status is forwarded to the chip's summary logic through a pending output only while the pin is unmasked. The wake status is forwarded through its own pending output whenever it is set.

Software reaches the pin through one control word. A write updates every control field at once. Each status bit in the same word is cleared by writing 1 to it. A read returns the control fields, the live pin level, both status bits and a flag for trigger settings that cannot be honoured. The same word also holds the output-enable and output-value bits that drive the pad, and three wake-enable bits, one for each of three sleep levels. Any of the three wake-enable bits allows wake status to be set.

Top module: `pinirq_detector`

## Requirements
- R1: After reset every control field, both status bits, `pad_oe`, `irq_pending` and `wake_pending` are 0.
- R2: Control word layout: bit 0 enable, bit 1 unmask, bit 2 trigger mode (0 edge, 1 level), bits 4:3 polarity, bit 5 output enable, bit 6 output value, bits 9:7 wake enables, bit 12 pin level (read only), bit 13 interrupt status, bit 14 wake status, bit 15 invalid-setting flag (read only). Every writable control field reads back as last written.
- R3: In edge mode with polarity 0, a rising pin level sets interrupt status on the clock edge after the rise; a falling level does not.
- R4: In edge mode with polarity 1, a falling level sets interrupt status and a rising level does not.
- R5: In edge mode with polarity 2, both rising and falling levels set interrupt status.
- R6: In level mode, polarity 0 sets status while the pin is high and polarity 1 while it is low. A clear written while the level is still active drops the status for one cycle, and the status is set again on the following clock edge.
- R7: With enable 0, no pin activity sets either status bit.
- R8: `irq_pending` is 1 exactly when interrupt status is 1 and unmask is 1; a masked status still reads back as 1.
- R9: Writing 1 to a status bit clears it; writing 0 leaves it unchanged. In edge mode an edge that arrives in the same cycle as a clear leaves the status set.
- R10: Wake status is set by a detected event only when at least one of the three wake enables is 1. `wake_pending` follows wake status regardless of unmask, and clearing one status bit leaves the other unchanged.
- R11: Polarity 3 in any mode, and polarity 2 in level mode, are invalid: bit 15 reads 1 and no status is generated.
- R12: `pad_oe` equals the output-enable bit and `pad_out` the output-value bit; bit 12 reads the input level whether output enable is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | 1 | Filtered pin input level |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | DATA_W | Control word write data |
| cfg_rdata | output | DATA_W | Control word read data |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| irq_pending | output | 1 | Unmasked interrupt status toward the summary logic |
| wake_pending | output | 1 | Wake status toward the summary logic |

## Verification
The hardest situation to reach is a status clear that lands in the same clock as a detection event. The outcome differs by mode: the edge wins in edge mode, and the clear wins for one cycle in level mode. The bench reaches it by driving the pin transition and the clearing write on the same falling clock edge, so that both are sampled by one rising edge. It then reads the status on the next two falling edges to see both the immediate result and the reassertion. Invalid polarity settings and a disabled pin are also driven with real toggles, so a missing gate shows up as a status bit that should have stayed 0.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  // Control word bit positions
  localparam int F_EN      = 0;
  localparam int F_UNMASK  = 1;
  localparam int F_LVL     = 2;
  localparam int F_POL_LO  = 3;
  localparam int F_OE      = 5;
  localparam int F_OVAL    = 6;
  localparam int F_WAKE_LO = 7;
  localparam int F_PIN     = 12;
  localparam int F_ISTS    = 13;
  localparam int F_WSTS    = 14;
  localparam int F_BAD     = 15;

  localparam int WAKE_N    = 3;
  localparam int STS_N     = 2;
  localparam int MIN_W     = F_BAD + 1;

  typedef enum logic [1:0] {
    POL_HIGH = 2'd0,
    POL_LOW  = 2'd1,
    POL_BOTH = 2'd2,
    POL_RSVD = 2'd3
  } pol_e;

  typedef struct packed {
    logic [WAKE_N-1:0] wake_en;
    logic              out_val;
    logic              out_en;
    pol_e              pol;
    logic              lvl;
    logic              unmask;
    logic              en;
  } ctrl_t;

endpackage

// File: rtl/pinirq_rst_sync.sv
module pinirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pinirq_ctrl_reg.sv
module pinirq_ctrl_reg
  import pinirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d.en      = wdata[F_EN];
      ctrl_d.unmask  = wdata[F_UNMASK];
      ctrl_d.lvl     = wdata[F_LVL];
      ctrl_d.pol     = pol_e'(wdata[F_POL_LO +: 2]);
      ctrl_d.out_en  = wdata[F_OE];
      ctrl_d.out_val = wdata[F_OVAL];
      ctrl_d.wake_en = wdata[F_WAKE_LO +: WAKE_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/pinirq_event.sv
module pinirq_event
  import pinirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic lvl,
  input  pol_e pol,
  output logic hit,
  output logic cfg_bad
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  assign rise = pin & ~prev_q;
  assign fall = ~pin & prev_q;

  always_comb begin
    hit     = 1'b0;
    cfg_bad = 1'b0;
    if (lvl) begin
      unique case (pol)
        POL_HIGH: hit = pin;
        POL_LOW:  hit = ~pin;
        default:  cfg_bad = 1'b1;
      endcase
    end else begin
      unique case (pol)
        POL_HIGH: hit = rise;
        POL_LOW:  hit = fall;
        POL_BOTH: hit = rise | fall;
        default:  cfg_bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pinirq_sticky.sv
module pinirq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic set_wins_i,
  output logic sts_o
);
  logic sts_q, sts_d;

  always_comb begin
    if (clr_i && !(set_i && set_wins_i)) sts_d = 1'b0;
    else                                 sts_d = sts_q | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/pinirq_detector.sv
module pinirq_detector
  import pinirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_level,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              pad_oe,
  output logic              pad_out,
  output logic              irq_pending,
  output logic              wake_pending
);
  localparam int HI_W = DATA_W - MIN_W;

  logic             rst_n_int;
  ctrl_t            ctrl;
  logic             hit;
  logic             cfg_bad;
  logic [STS_N-1:0] set_vec;
  logic [STS_N-1:0] clr_vec;
  logic [STS_N-1:0] sts;
  logic             unused_wbits;

  pinirq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pinirq_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .ctrl  (ctrl)
  );

  pinirq_event u_evt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .pin     (pin_level),
    .lvl     (ctrl.lvl),
    .pol     (ctrl.pol),
    .hit     (hit),
    .cfg_bad (cfg_bad)
  );

  // index 0: interrupt status, index 1: wake status
  always_comb begin
    set_vec[0] = hit & ctrl.en;
    set_vec[1] = hit & ctrl.en & (|ctrl.wake_en);
    clr_vec[0] = cfg_we & cfg_wdata[F_ISTS];
    clr_vec[1] = cfg_we & cfg_wdata[F_WSTS];
  end

  for (genvar k = 0; k < STS_N; k++) begin : g_sts
    pinirq_sticky u_sts (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .set_i      (set_vec[k]),
      .clr_i      (clr_vec[k]),
      .set_wins_i (~ctrl.lvl),
      .sts_o      (sts[k])
    );
  end

  always_comb begin
    cfg_rdata                         = '0;
    cfg_rdata[F_EN]                   = ctrl.en;
    cfg_rdata[F_UNMASK]               = ctrl.unmask;
    cfg_rdata[F_LVL]                  = ctrl.lvl;
    cfg_rdata[F_POL_LO +: 2]          = ctrl.pol;
    cfg_rdata[F_OE]                   = ctrl.out_en;
    cfg_rdata[F_OVAL]                 = ctrl.out_val;
    cfg_rdata[F_WAKE_LO +: WAKE_N]    = ctrl.wake_en;
    cfg_rdata[F_PIN]                  = pin_level;
    cfg_rdata[F_ISTS]                 = sts[0];
    cfg_rdata[F_WSTS]                 = sts[1];
    cfg_rdata[F_BAD]                  = cfg_bad;
  end

  assign pad_oe       = ctrl.out_en;
  assign pad_out      = ctrl.out_val;
  assign irq_pending  = sts[0] & ctrl.unmask;
  assign wake_pending = sts[1];

  generate
    if (HI_W > 0) begin : g_hi
      assign unused_wbits = ^{cfg_wdata[DATA_W-1:MIN_W], cfg_wdata[F_BAD],
                              cfg_wdata[F_PIN], cfg_wdata[F_PIN-1:F_WAKE_LO+WAKE_N]};
    end else begin : g_nohi
      assign unused_wbits = ^{cfg_wdata[F_BAD], cfg_wdata[F_PIN],
                              cfg_wdata[F_PIN-1:F_WAKE_LO+WAKE_N]};
    end
  endgenerate
endmodule

// File: rtl/pinirq_detector_chk.sv
module pinirq_detector_chk
  import pinirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              pad_oe,
  input logic              irq_pending,
  input logic              wake_pending
);
  assert_pending_needs_unmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (cfg_rdata[F_ISTS] && cfg_rdata[F_UNMASK]));

  assert_no_status_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[F_ISTS]) |-> $past(cfg_rdata[F_EN]));

  assert_level_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[F_ISTS] && cfg_rdata[F_LVL]) |=> !cfg_rdata[F_ISTS]);

  assert_invalid_blocks_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[F_ISTS]) |-> !$past(cfg_rdata[F_BAD]));

  assert_wake_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[F_WSTS]) |-> $past(|cfg_rdata[F_WAKE_LO +: WAKE_N]));

  assert_wake_pending_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pending |-> cfg_rdata[F_WSTS]);

  assert_pad_oe_tracks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> cfg_rdata[F_OE]);
endmodule

bind pinirq_detector pinirq_detector_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .pad_oe       (pad_oe),
  .irq_pending  (irq_pending),
  .wake_pending (wake_pending)
);

// File: tb/pinirq_detector_tb.sv
module pinirq_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          pin_level;
  logic          cfg_we;
  logic [DW-1:0] cfg_wdata;
  logic [DW-1:0] cfg_rdata;
  logic          pad_oe, pad_out, irq_pending, wake_pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pinirq_detector #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pad_oe(pad_oe), .pad_out(pad_out),
    .irq_pending(irq_pending), .wake_pending(wake_pending)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Field positions taken from R2
  function automatic logic [DW-1:0] cw(input bit en, input bit unm, input bit lvl,
                                       input int pol, input bit oe, input bit ov,
                                       input int wk, input bit ci, input bit cwk);
    logic [DW-1:0] w;
    w = '0;
    w[0] = en; w[1] = unm; w[2] = lvl; w[4:3] = pol[1:0];
    w[5] = oe; w[6] = ov; w[9:7] = wk[2:0]; w[13] = ci; w[14] = cwk;
    return w;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin_level = v;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(cw(0,0,0,0,0,0,0,1,1));
    set_pin(1'b0);
    cyc(2);
    wr(cw(0,0,0,0,0,0,0,1,1));
  endtask

  task automatic t_reset();
    chk("R1 rdata", cfg_rdata, '0);
    chk("R1 pad_oe", pad_oe, 1'b0);
    chk("R1 irq_pending", irq_pending, 1'b0);
    chk("R1 wake_pending", wake_pending, 1'b0);
  endtask

  task automatic t_readback();
    quiesce();
    wr(cw(1,0,1,1,0,1,5,0,0));
    chk("R2 fields", cfg_rdata[9:0], cw(1,0,1,1,0,1,5,0,0) & 32'h3ff);
    quiesce();
  endtask

  task automatic t_rise();
    quiesce();
    wr(cw(1,1,0,0,0,0,0,0,0));
    set_pin(1'b1); @(negedge clk);
    chk("R3 rise sets", cfg_rdata[13], 1'b1);
    chk("R3 pending", irq_pending, 1'b1);
    wr(cw(1,1,0,0,0,0,0,1,0));
    chk("R9 clear", cfg_rdata[13], 1'b0);
    set_pin(1'b0); @(negedge clk);
    chk("R3 fall ignored", cfg_rdata[13], 1'b0);
  endtask

  task automatic t_fall();
    quiesce();
    wr(cw(1,1,0,1,0,0,0,0,0));
    set_pin(1'b1); @(negedge clk);
    chk("R4 rise ignored", cfg_rdata[13], 1'b0);
    set_pin(1'b0); @(negedge clk);
    chk("R4 fall sets", cfg_rdata[13], 1'b1);
  endtask

  task automatic t_both();
    quiesce();
    wr(cw(1,1,0,2,0,0,0,0,0));
    set_pin(1'b1); @(negedge clk);
    chk("R5 rise sets", cfg_rdata[13], 1'b1);
    wr(cw(1,1,0,2,0,0,0,1,0));
    chk("R5 cleared", cfg_rdata[13], 1'b0);
    set_pin(1'b0); @(negedge clk);
    chk("R5 fall sets", cfg_rdata[13], 1'b1);
  endtask

  task automatic t_level();
    quiesce();
    wr(cw(1,1,1,0,0,0,0,0,0));
    cyc(1);
    chk("R6 high level idle", cfg_rdata[13], 1'b0);
    set_pin(1'b1); @(negedge clk);
    chk("R6 high level sets", cfg_rdata[13], 1'b1);
    wr(cw(1,1,1,0,0,0,0,1,0));
    chk("R6 clear drops", cfg_rdata[13], 1'b0);
    @(negedge clk);
    chk("R6 reasserts", cfg_rdata[13], 1'b1);
    set_pin(1'b0);
    wr(cw(1,1,1,0,0,0,0,1,0));
    cyc(1);
    chk("R6 stays clear", cfg_rdata[13], 1'b0);
    wr(cw(1,1,1,1,0,0,0,0,0));
    @(negedge clk);
    chk("R6 low level sets", cfg_rdata[13], 1'b1);
  endtask

  task automatic t_disabled();
    quiesce();
    wr(cw(0,1,0,2,0,0,7,0,0));
    set_pin(1'b1); set_pin(1'b0); cyc(2);
    chk("R7 edge no ists", cfg_rdata[13], 1'b0);
    chk("R7 edge no wsts", cfg_rdata[14], 1'b0);
    wr(cw(0,1,1,1,0,0,7,0,0));
    cyc(3);
    chk("R7 level no ists", cfg_rdata[14:13], 2'b00);
  endtask

  task automatic t_mask_w1c();
    quiesce();
    wr(cw(1,0,0,0,0,0,0,0,0));
    set_pin(1'b1); @(negedge clk);
    chk("R8 masked status reads", cfg_rdata[13], 1'b1);
    chk("R8 masked no pending", irq_pending, 1'b0);
    wr(cw(1,1,0,0,0,0,0,0,0));
    chk("R8 unmask pending", irq_pending, 1'b1);
    chk("R9 write 0 keeps", cfg_rdata[13], 1'b1);
    set_pin(1'b0); cyc(1);
    wr(cw(1,1,0,0,0,0,0,1,0));
    chk("R9 cleared", cfg_rdata[13], 1'b0);
    // edge and clear on the same clock edge
    @(negedge clk);
    pin_level = 1'b1; cfg_we = 1'b1; cfg_wdata = cw(1,1,0,0,0,0,0,1,0);
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
    chk("R9 edge beats clear", cfg_rdata[13], 1'b1);
  endtask

  task automatic t_wake();
    quiesce();
    wr(cw(1,0,0,0,0,0,0,0,0));
    set_pin(1'b1); @(negedge clk);
    chk("R10 no wake enable", cfg_rdata[14], 1'b0);
    chk("R10 no wake pending", wake_pending, 1'b0);
    set_pin(1'b0);
    wr(cw(1,0,0,0,0,0,4,1,1));
    set_pin(1'b1); @(negedge clk);
    chk("R10 wake set", cfg_rdata[14], 1'b1);
    chk("R10 wake pending masked irq", {wake_pending, irq_pending}, 2'b10);
    wr(cw(1,0,0,0,0,0,4,0,1));
    chk("R10 wake cleared, irq kept", cfg_rdata[14:13], 2'b01);
  endtask

  task automatic t_invalid();
    quiesce();
    wr(cw(1,1,1,2,0,0,7,0,0));
    chk("R11 level both flag", cfg_rdata[15], 1'b1);
    set_pin(1'b1); cyc(2); set_pin(1'b0); cyc(2);
    chk("R11 level both no status", cfg_rdata[14:13], 2'b00);
    wr(cw(1,1,0,3,0,0,7,0,0));
    chk("R11 edge rsvd flag", cfg_rdata[15], 1'b1);
    set_pin(1'b1); set_pin(1'b0); cyc(1);
    chk("R11 edge rsvd no status", cfg_rdata[14:13], 2'b00);
    wr(cw(1,1,0,2,0,0,7,0,0));
    chk("R11 edge both valid", cfg_rdata[15], 1'b0);
  endtask

  task automatic t_pad();
    quiesce();
    wr(cw(0,0,0,0,1,1,0,0,0));
    chk("R12 pad drive", {pad_oe, pad_out}, 2'b11);
    set_pin(1'b0); @(negedge clk);
    chk("R12 pin low with oe", cfg_rdata[12], 1'b0);
    set_pin(1'b1); @(negedge clk);
    chk("R12 pin high with oe", cfg_rdata[12], 1'b1);
    wr(cw(0,0,0,0,0,0,0,0,0));
    chk("R12 oe off", {pad_oe, pad_out}, 2'b00);
    chk("R12 pin high without oe", cfg_rdata[12], 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_level = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_readback();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_disabled();
    t_mask_w1c();
    t_wake();
    t_invalid();
    t_pad();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule